// File: doc/BRIEF.md
# Two-Tier Token Structure Memory

This block is the structure memory of a token-driven dataflow machine. Each input token carries an operation code, an address, a data word, a compare word and a return route. When the operation produces a value, the block sends back a result token holding that value and a return route. The address space is divided at a parameter `BOUNDARY`. Below it every address is a single-assignment cell with a presence state, and a read of an unwritten cell is parked until a write arrives. At or above it the addresses map to a flat word store that never blocks and accepts only plain reads and writes.

The block holds `UNITS` independent lanes. Each lane has its own token input, its own result output, its own presence-tracked cells and its own single deferred-read register. All lanes share one flat store, so a word written through one lane can be read through any other.

Each lane is a two-state controller. In `ST_IDLE` the lane may accept a token. The transition `ST_IDLE -> ST_HOLD` is taken when an accepted token produces a result. The lane stays in `ST_HOLD -> ST_HOLD` while the output is not accepted. It takes `ST_HOLD -> ST_IDLE` on the cycle `out_ready` is high. An accepted token that yields no result leaves the lane in `ST_IDLE`. Presence states are `PR_EMPTY`, `PR_WAITING` and `PR_FULL`.

Top module: `tiered_smem`

## Requirements
- R1: Operation codes on a lane's 3-bit `in_op` field are READ=0, WRITE=1, CLEAR=2, ALLOC=3, FREE=4, FETCH_INC=5, FETCH_DEC=6, SWAP_EQ=7. An address strictly below `BOUNDARY` (default 256) selects the presence-tracked tier. Any other address selects the flat tier at word index address minus `BOUNDARY`.
- R2: After reset every cell is EMPTY, every flat word is 0, no lane is deferred, `out_valid` and `err` are low, and an idle lane raises `in_ready`.
- R3: A READ of a FULL cell is accepted, and on the next cycle `out_valid` is high with the cell data and the token's route.
- R4: A READ of an EMPTY cell produces no result. The cell becomes WAITING, and its address and route are saved in the lane's deferred-read register.
- R5: A WRITE to a WAITING cell stores the data and makes the cell FULL. On the next cycle it emits a result carrying the written data and the saved route, and it frees the deferred-read register.
- R6: A WRITE to an EMPTY cell makes it FULL with no result. A WRITE to a FULL cell pulses `err` for one cycle and leaves the stored data unchanged.
- R7: In the flat tier, a WRITE overwrites the word with no presence check. A READ is never deferred, returns on the next cycle, and returns 0 for a word never written.
- R8: Operations 2 through 7 aimed at a flat-tier address pulse `err` for one cycle. They emit no result and leave the flat store unchanged.
- R9: The flat store is shared by all lanes. Two writes to the same word in one cycle leave the value from the highest-numbered lane. A read in the same cycle as a write returns the earlier value.
- R10: While a lane's deferred-read register is occupied, that lane holds `in_ready` low for a READ whose cell is not FULL. READs of FULL cells and all other tokens are still accepted.
- R11: A result is held with its data and route unchanged until `out_ready` is high. The lane accepts no token while a result is pending.
- R12: CLEAR, ALLOC and FREE in the presence tier set the cell to EMPTY with no result and no change to its data. If the cell was WAITING, the deferred read is dropped and the register is freed.
- R13: FETCH_INC, FETCH_DEC and SWAP_EQ on a FULL cell return the old data. They then store old+1, old-1, or (for SWAP_EQ) the token data if old equals the compare word, otherwise old. On a cell that is not FULL they pulse `err` and emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | UNITS | Token valid per lane |
| in_ready | output | UNITS | Token accepted per lane |
| in_op | input | UNITS*3 | Operation code, 3 bits per lane |
| in_addr | input | UNITS*AW | Address per lane |
| in_data | input | UNITS*DW | Write or swap data per lane |
| in_cmp | input | UNITS*DW | Compare word for SWAP_EQ per lane |
| in_route | input | UNITS*RW | Return route per lane |
| out_valid | output | UNITS | Result token valid per lane |
| out_ready | input | UNITS | Result token accepted per lane |
| out_data | output | UNITS*DW | Result data per lane |
| out_route | output | UNITS*RW | Result route per lane |
| err | output | UNITS | One-cycle error pulse per lane |

## Verification
The bench builds the block with `UNITS=2`, `AW=6`, `DW=16`, `RW=6` and `BOUNDARY=40`. With these values the flat tier has 24 words, and because the boundary is not a power of two the index subtraction is really tested. Addresses 39 and 40 put both sides of the boundary, the top flat word and every presence state within a few dozen tokens. Two lanes are enough to show sharing of the flat store and same-cycle write collisions. A random phase with a stalled output keeps deferred-read stalls and hold cycles overlapping.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_CLEAR  = 3'd2,
        OP_ALLOC  = 3'd3,
        OP_FREE   = 3'd4,
        OP_FINC   = 3'd5,
        OP_FDEC   = 3'd6,
        OP_SWAPEQ = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PR_EMPTY   = 2'd0,
        PR_WAITING = 2'd1,
        PR_FULL    = 2'd2
    } pres_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } lane_st_e;
endpackage

// File: rtl/smem_flat.sv
module smem_flat #(
    parameter int UNITS  = 2,
    parameter int IDX_W  = 8,
    parameter int DW     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [UNITS-1:0]       we,
    input  logic [UNITS*IDX_W-1:0] widx,
    input  logic [UNITS*DW-1:0]    wdata,
    input  logic [UNITS*IDX_W-1:0] ridx,
    output logic [UNITS*DW-1:0]    rdata
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DW-1:0] mem [SLOTS];

    // Lanes are visited in ascending order, so the highest lane wins a collision (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else begin
            for (int u = 0; u < UNITS; u++) begin
                if (we[u]) mem[widx[u*IDX_W +: IDX_W]] <= wdata[u*DW +: DW];
            end
        end
    end

    for (genvar g = 0; g < UNITS; g++) begin : g_rd
        assign rdata[g*DW +: DW] = mem[ridx[g*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/smem_lane.sv
module smem_lane
    import smem_pkg::*;
#(
    parameter int AW       = 9,
    parameter int DW       = 16,
    parameter int RW       = 8,
    parameter int BOUNDARY = 256,
    parameter int FIDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [AW-1:0]     in_addr,
    input  logic [DW-1:0]     in_data,
    input  logic [DW-1:0]     in_cmp,
    input  logic [RW-1:0]     in_route,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic [RW-1:0]     out_route,
    output logic              err,
    output logic              flat_we,
    output logic [FIDX_W-1:0] flat_idx,
    output logic [DW-1:0]     flat_wdata,
    input  logic [DW-1:0]     flat_rdata
);
    localparam int CIDX_W = (BOUNDARY > 1) ? $clog2(BOUNDARY) : 1;
    localparam int CSLOTS = 1 << CIDX_W;

    lane_st_e state, state_nx;
    pres_e    pres  [CSLOTS];
    logic [DW-1:0] cdata [CSLOTS];

    logic              def_busy;
    logic [CIDX_W-1:0] def_addr;
    logic [RW-1:0]     def_route;

    op_e               op;
    logic              tier1, stall, fire;
    logic [CIDX_W-1:0] cidx;
    pres_e             cur_pres;
    logic [DW-1:0]     cur_data;

    logic              emit, raise_err, wr_pres, wr_data, def_set, def_clr, flat_do;
    logic [DW-1:0]     emit_data, new_data;
    logic [RW-1:0]     emit_route;
    pres_e             new_pres;

    assign op       = op_e'(in_op);
    assign tier1    = in_addr < AW'(BOUNDARY);
    assign cidx     = in_addr[CIDX_W-1:0];
    assign cur_pres = pres[cidx];
    assign cur_data = cdata[cidx];
    assign flat_idx = FIDX_W'(in_addr - AW'(BOUNDARY));
    assign flat_wdata = in_data;

    assign stall    = (op == OP_READ) && tier1 && (cur_pres != PR_FULL) && def_busy;
    assign in_ready = (state == ST_IDLE) && !stall;
    assign fire     = in_valid && in_ready;
    assign flat_we  = fire && flat_do;
    assign out_valid = (state == ST_HOLD);

    // Operation decode for both tiers
    always_comb begin
        emit = 1'b0; emit_data = cur_data; emit_route = in_route;
        raise_err = 1'b0; wr_pres = 1'b0; new_pres = cur_pres;
        wr_data = 1'b0; new_data = in_data;
        def_set = 1'b0; def_clr = 1'b0; flat_do = 1'b0;
        if (tier1) begin
            unique case (op)
                OP_READ: begin
                    if (cur_pres == PR_FULL) emit = 1'b1;
                    else begin
                        wr_pres = 1'b1; new_pres = PR_WAITING; def_set = 1'b1;
                    end
                end
                OP_WRITE: begin
                    unique case (cur_pres)
                        PR_FULL: raise_err = 1'b1;
                        PR_WAITING: begin
                            emit = 1'b1; emit_data = in_data; emit_route = def_route;
                            def_clr = 1'b1; wr_pres = 1'b1; new_pres = PR_FULL; wr_data = 1'b1;
                        end
                        default: begin
                            wr_pres = 1'b1; new_pres = PR_FULL; wr_data = 1'b1;
                        end
                    endcase
                end
                OP_CLEAR, OP_ALLOC, OP_FREE: begin
                    wr_pres = 1'b1; new_pres = PR_EMPTY;
                    def_clr = (cur_pres == PR_WAITING);
                end
                default: begin
                    if (cur_pres == PR_FULL) begin
                        emit = 1'b1; wr_data = 1'b1;
                        if (op == OP_FINC)      new_data = cur_data + DW'(1);
                        else if (op == OP_FDEC) new_data = cur_data - DW'(1);
                        else                    new_data = (cur_data == in_cmp) ? in_data : cur_data;
                    end else begin
                        raise_err = 1'b1;
                    end
                end
            endcase
        end else begin
            unique case (op)
                OP_READ:  begin emit = 1'b1; emit_data = flat_rdata; end
                OP_WRITE: flat_do = 1'b1;
                default:  raise_err = 1'b1;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (fire && emit) state_nx = ST_HOLD;
            ST_HOLD: if (out_ready)    state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0; out_route <= '0; err <= 1'b0;
        end else begin
            err <= fire && raise_err;
            if (fire && emit) begin
                out_data  <= emit_data;
                out_route <= emit_route;
            end
        end
    end

    // Cell and deferred-read storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CSLOTS; i++) begin
                pres[i]  <= PR_EMPTY;
                cdata[i] <= '0;
            end
            def_busy <= 1'b0; def_addr <= '0; def_route <= '0;
        end else if (fire) begin
            if (wr_pres) pres[cidx]  <= new_pres;
            if (wr_data) cdata[cidx] <= new_data;
            if (def_set) begin
                def_busy <= 1'b1; def_addr <= cidx; def_route <= in_route;
            end else if (def_clr) begin
                def_busy <= 1'b0;
            end
        end
    end

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_route));
    a_r11_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r4_deferred_cell_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        def_busy |-> pres[def_addr] == PR_WAITING);
    a_r10_busy_read_hits_full: assert property (@(posedge clk) disable iff (!rst_n)
        fire && def_busy && tier1 && op == OP_READ |-> cur_pres == PR_FULL);
    a_r7_flat_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !tier1 && op == OP_READ |=> out_valid);
    a_r8_flat_reject: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !tier1 && op != OP_READ && op != OP_WRITE |=> err && !out_valid && $past(!flat_we));
    a_r6_err_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(fire));
endmodule

// File: rtl/tiered_smem.sv
module tiered_smem #(
    parameter int UNITS    = 2,
    parameter int AW       = 9,
    parameter int DW       = 16,
    parameter int RW       = 8,
    parameter int BOUNDARY = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [UNITS-1:0]    in_valid,
    output logic [UNITS-1:0]    in_ready,
    input  logic [UNITS*3-1:0]  in_op,
    input  logic [UNITS*AW-1:0] in_addr,
    input  logic [UNITS*DW-1:0] in_data,
    input  logic [UNITS*DW-1:0] in_cmp,
    input  logic [UNITS*RW-1:0] in_route,
    output logic [UNITS-1:0]    out_valid,
    input  logic [UNITS-1:0]    out_ready,
    output logic [UNITS*DW-1:0] out_data,
    output logic [UNITS*RW-1:0] out_route,
    output logic [UNITS-1:0]    err
);
    localparam int FLAT_DEPTH = (1 << AW) - BOUNDARY;
    localparam int FIDX_W     = (FLAT_DEPTH > 1) ? $clog2(FLAT_DEPTH) : 1;

    logic [UNITS-1:0]        f_we;
    logic [UNITS*FIDX_W-1:0] f_idx;
    logic [UNITS*DW-1:0]     f_wdata, f_rdata;

    for (genvar g = 0; g < UNITS; g++) begin : g_lane
        smem_lane #(
            .AW(AW), .DW(DW), .RW(RW), .BOUNDARY(BOUNDARY), .FIDX_W(FIDX_W)
        ) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[g]),
            .in_ready   (in_ready[g]),
            .in_op      (in_op[g*3 +: 3]),
            .in_addr    (in_addr[g*AW +: AW]),
            .in_data    (in_data[g*DW +: DW]),
            .in_cmp     (in_cmp[g*DW +: DW]),
            .in_route   (in_route[g*RW +: RW]),
            .out_valid  (out_valid[g]),
            .out_ready  (out_ready[g]),
            .out_data   (out_data[g*DW +: DW]),
            .out_route  (out_route[g*RW +: RW]),
            .err        (err[g]),
            .flat_we    (f_we[g]),
            .flat_idx   (f_idx[g*FIDX_W +: FIDX_W]),
            .flat_wdata (f_wdata[g*DW +: DW]),
            .flat_rdata (f_rdata[g*DW +: DW])
        );
    end

    smem_flat #(.UNITS(UNITS), .IDX_W(FIDX_W), .DW(DW)) flat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (f_we),
        .widx  (f_idx),
        .wdata (f_wdata),
        .ridx  (f_idx),
        .rdata (f_rdata)
    );
endmodule

// File: tb/tiered_smem_tb_top.sv
`timescale 1ns/1ps
module tiered_smem_tb_top;
    localparam int U = 2, AW = 6, DW = 16, RW = 6, B = 40;
    localparam int NA = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [U-1:0] in_valid = '0, out_ready = '1;
    logic [U*3-1:0]  in_op = '0;
    logic [U*AW-1:0] in_addr = '0;
    logic [U*DW-1:0] in_data = '0, in_cmp = '0;
    logic [U*RW-1:0] in_route = '0;
    logic [U-1:0] in_ready, out_valid, err;
    logic [U*DW-1:0] out_data;
    logic [U*RW-1:0] out_route;

    always #4 clk = ~clk;

    tiered_smem #(.UNITS(U), .AW(AW), .DW(DW), .RW(RW), .BOUNDARY(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .in_data(in_data), .in_cmp(in_cmp),
        .in_route(in_route), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_route(out_route), .err(err));

    int nchk = 0, nerr = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model (presence: 0 empty, 1 waiting, 2 full)
    int mpres [U][NA];
    int mdata [U][NA];
    int mflat [NA];
    bit mhold [U], merr [U], mdb [U];
    int mod [U], mor [U], mdr [U];

    function automatic bit m_ready(int l);
        int op, a;
        op = int'(in_op[l*3 +: 3]);
        a  = int'(in_addr[l*AW +: AW]);
        return !mhold[l] && !(op == 0 && a < B && mpres[l][a] != 2 && mdb[l]);
    endfunction

    always @(posedge clk) begin
        bit acc [U];
        int rd [U];
        if (!rst_n) begin
            for (int l = 0; l < U; l++) begin
                for (int a = 0; a < NA; a++) begin mpres[l][a] = 0; mdata[l][a] = 0; end
                mhold[l] = 0; merr[l] = 0; mdb[l] = 0; mod[l] = 0; mor[l] = 0; mdr[l] = 0;
            end
            for (int a = 0; a < NA; a++) mflat[a] = 0;
        end else begin
            for (int l = 0; l < U; l++) begin
                int a;
                a = int'(in_addr[l*AW +: AW]);
                acc[l] = in_valid[l] && m_ready(l);
                rd[l]  = (a >= B) ? mflat[a-B] : 0;
            end
            for (int l = 0; l < U; l++) begin
                int op, a, d, c, r, old;
                op = int'(in_op[l*3 +: 3]); a = int'(in_addr[l*AW +: AW]);
                d = int'(in_data[l*DW +: DW]); c = int'(in_cmp[l*DW +: DW]);
                r = int'(in_route[l*RW +: RW]);
                merr[l] = 0;
                if (mhold[l] && out_ready[l]) mhold[l] = 0;
                if (acc[l]) begin
                    if (a >= B) begin
                        if (op == 0) begin mhold[l] = 1; mod[l] = rd[l]; mor[l] = r; end
                        else if (op == 1) mflat[a-B] = d;
                        else merr[l] = 1;
                    end else begin
                        old = mdata[l][a];
                        if (op == 0) begin
                            if (mpres[l][a] == 2) begin mhold[l] = 1; mod[l] = old; mor[l] = r; end
                            else begin mpres[l][a] = 1; mdb[l] = 1; mdr[l] = r; end
                        end else if (op == 1) begin
                            if (mpres[l][a] == 2) merr[l] = 1;
                            else begin
                                if (mpres[l][a] == 1) begin
                                    mhold[l] = 1; mod[l] = d; mor[l] = mdr[l]; mdb[l] = 0;
                                end
                                mpres[l][a] = 2; mdata[l][a] = d;
                            end
                        end else if (op <= 4) begin
                            if (mpres[l][a] == 1) mdb[l] = 0;
                            mpres[l][a] = 0;
                        end else if (mpres[l][a] == 2) begin
                            mhold[l] = 1; mod[l] = old; mor[l] = r;
                            if (op == 5) mdata[l][a] = (old + 1) & 16'hFFFF;
                            else if (op == 6) mdata[l][a] = (old - 1) & 16'hFFFF;
                            else if (old == c) mdata[l][a] = d;
                        end else merr[l] = 1;
                    end
                end
            end
        end
    end

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < U; l++) begin
                chk(in_ready[l] == m_ready(l), "R10 model in_ready", int'(in_ready[l]), int'(m_ready(l)));
                chk(out_valid[l] == mhold[l], "R11 model out_valid", int'(out_valid[l]), int'(mhold[l]));
                chk(err[l] == merr[l], "R8 model err", int'(err[l]), int'(merr[l]));
                if (mhold[l]) begin
                    chk(int'(out_data[l*DW +: DW]) == mod[l], "R3 model out_data", int'(out_data[l*DW +: DW]), mod[l]);
                    chk(int'(out_route[l*RW +: RW]) == mor[l], "R3 model out_route", int'(out_route[l*RW +: RW]), mor[l]);
                end
            end
        end
    end

    task automatic drive(int l, int op, int a, int d, int c, int r);
        in_op[l*3 +: 3] = 3'(op); in_addr[l*AW +: AW] = AW'(a);
        in_data[l*DW +: DW] = DW'(d); in_cmp[l*DW +: DW] = DW'(c);
        in_route[l*RW +: RW] = RW'(r);
    endtask

    task automatic send(int l, int op, int a, int d, int c, int r);
        drive(l, op, a, d, c, r);
        in_valid[l] = 1'b1;
        @(negedge clk);
        while (!in_ready[l]) @(negedge clk);
        @(posedge clk); #2;
        in_valid[l] = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic expect_tok(int l, string tag, int d, int r);
        chk(out_valid[l] == 1'b1, tag, int'(out_valid[l]), 1);
        chk(int'(out_data[l*DW +: DW]) == d, tag, int'(out_data[l*DW +: DW]), d);
        chk(int'(out_route[l*RW +: RW]) == r, tag, int'(out_route[l*RW +: RW]), r);
    endtask

    task automatic expect_none(int l, string tag, bit e);
        chk(out_valid[l] == 1'b0, tag, int'(out_valid[l]), 0);
        chk(err[l] == e, tag, int'(err[l]), int'(e));
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R2 reset out_valid", int'(out_valid), 0);
        chk(err == '0, "R2 reset err", int'(err), 0);
        chk(in_ready == '1, "R2 reset in_ready", int'(in_ready), 3);
        tick();

        // R6 / R3 single assignment and direct read
        send(0, 1, 5, 'h1234, 0, 0);     expect_none(0, "R6 write empty", 0);
        send(0, 0, 5, 0, 0, 7);          expect_tok(0, "R3 read full", 'h1234, 7);
        send(0, 1, 5, 'h9999, 0, 0);     expect_none(0, "R6 write full err", 1);
        send(0, 0, 5, 0, 0, 2);          expect_tok(0, "R6 data kept", 'h1234, 2);

        // R4 defer, R10 stall, R5 wake-up
        send(0, 0, 10, 0, 0, 3);         expect_none(0, "R4 read empty defers", 0);
        tick(); chk(out_valid[0] == 1'b0, "R4 still no token", int'(out_valid[0]), 0);
        drive(0, 0, 11, 0, 0, 1); in_valid[0] = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(in_ready[0] == 1'b0, "R10 stall empty read", int'(in_ready[0]), 0);
        end
        @(posedge clk); #2 in_valid[0] = 1'b0;
        send(0, 0, 5, 0, 0, 4);          expect_tok(0, "R10 full read while busy", 'h1234, 4);
        send(0, 1, 10, 'h0abc, 0, 0);    expect_tok(0, "R5 wake deferred", 'h0abc, 3);
        send(0, 0, 10, 0, 0, 6);         expect_tok(0, "R5 cell now full", 'h0abc, 6);

        // R1 boundary and R7 flat tier
        send(0, 0, 39, 0, 0, 9);         expect_none(0, "R1 addr 39 is presence tier", 0);
        send(0, 1, 39, 'h55, 0, 0);      expect_tok(0, "R1 addr 39 wake", 'h55, 9);
        send(0, 0, 40, 0, 0, 1);         expect_tok(0, "R7 unwritten flat reads 0", 0, 1);
        send(0, 1, 40, 'h1111, 0, 0);    expect_none(0, "R7 flat write", 0);
        send(0, 1, 40, 'h2222, 0, 0);
        send(0, 0, 40, 0, 0, 2);         expect_tok(0, "R7 flat overwrite", 'h2222, 2);
        send(0, 1, 63, 'h7777, 0, 0);
        send(0, 0, 63, 0, 0, 3);         expect_tok(0, "R1 top flat word", 'h7777, 3);
        send(0, 0, 62, 0, 0, 3);         expect_tok(0, "R1 neighbour untouched", 0, 3);

        // R8 rejection in the flat tier
        send(0, 2, 40, 0, 0, 0);         expect_none(0, "R8 clear rejected", 1);
        send(0, 5, 40, 0, 0, 0);         expect_none(0, "R8 fetch_inc rejected", 1);
        send(0, 7, 40, 'h3333, 'h2222, 0); expect_none(0, "R8 swap rejected", 1);
        send(0, 0, 40, 0, 0, 5);         expect_tok(0, "R8 flat unchanged", 'h2222, 5);

        // R9 sharing between lanes
        send(1, 0, 40, 0, 0, 8);         expect_tok(1, "R9 lane1 sees lane0 write", 'h2222, 8);
        send(1, 1, 41, 'h4242, 0, 0);
        send(0, 0, 41, 0, 0, 8);         expect_tok(0, "R9 lane0 sees lane1 write", 'h4242, 8);
        drive(0, 1, 42, 'h00a0, 0, 0); drive(1, 1, 42, 'h00b1, 0, 0);
        in_valid = 2'b11; tick(); in_valid = 2'b00;
        send(0, 0, 42, 0, 0, 1);         expect_tok(0, "R9 collision high lane wins", 'h00b1, 1);

        // R12 clear / free in presence tier
        send(1, 0, 7, 0, 0, 9);          expect_none(1, "R12 defer before clear", 0);
        send(1, 2, 7, 0, 0, 0);          expect_none(1, "R12 clear no token", 0);
        send(1, 1, 7, 'h77, 0, 0);       expect_none(1, "R12 cleared cell empty", 0);
        send(1, 0, 7, 0, 0, 2);          expect_tok(1, "R12 read after clear", 'h77, 2);
        send(1, 4, 7, 0, 0, 0);          expect_none(1, "R12 free", 0);
        send(1, 0, 7, 0, 0, 5);          expect_none(1, "R12 freed cell defers", 0);
        send(1, 1, 7, 'h78, 0, 0);       expect_tok(1, "R12 freed cell wake", 'h78, 5);

        // R13 atomics on presence tier
        send(0, 5, 5, 0, 0, 1);          expect_tok(0, "R13 fetch_inc old", 'h1234, 1);
        send(0, 6, 5, 0, 0, 1);          expect_tok(0, "R13 fetch_dec old", 'h1235, 1);
        send(0, 7, 5, 'h0005, 'h1234, 1); expect_tok(0, "R13 swap match old", 'h1234, 1);
        send(0, 7, 5, 'h0006, 'h0009, 1); expect_tok(0, "R13 swap miss old", 'h0005, 1);
        send(0, 0, 5, 0, 0, 2);          expect_tok(0, "R13 swap miss kept", 'h0005, 2);
        send(0, 5, 20, 0, 0, 0);         expect_none(0, "R13 atomic on empty err", 1);

        // R11 output hold
        out_ready[0] = 1'b0;
        send(0, 0, 5, 0, 0, 3);          expect_tok(0, "R11 token pending", 5, 3);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid[0] && int'(out_data[DW-1:0]) == 5, "R11 held stable", int'(out_data[DW-1:0]), 5);
            chk(in_ready[0] == 1'b0, "R11 no accept while pending", int'(in_ready[0]), 0);
        end
        out_ready[0] = 1'b1;
        tick();
        chk(out_valid[0] == 1'b0, "R11 released", int'(out_valid[0]), 0);

        // Random traffic checked by the model
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #2;
            for (int l = 0; l < U; l++) begin
                int r, op, a;
                r  = $urandom_range(0, 9);
                op = (r < 4) ? 0 : (r < 7) ? 1 : $urandom_range(2, 7);
                a  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 7) : $urandom_range(36, 47);
                drive(l, op, a, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 63));
                in_valid[l]  = ($urandom_range(0, 2) != 0);
                out_ready[l] = ($urandom_range(0, 3) != 0);
            end
        end
        in_valid = '0; out_ready = '1;
        repeat (4) tick();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule